// File: doc/BRIEF.md
# Multi-Channel Digitizer Calibration and Baseline Removal Pipeline

This block sits between a bank of free-running digitizers and a trigger processor. Each channel takes one raw 10-bit sample per clock with a valid strobe. The sample goes through a fixed-depth register pipeline. A per-channel calibration table turns the raw code into a linearized value. A host-loaded pedestal is subtracted from that value, giving an 11-bit signed result, and a flag marks samples above a host-loaded signed level. The data, the flag and the valid strobe stay aligned, so the trigger sees every channel with the same fixed latency.

The host programs three things per channel through shared write ports that carry a channel index: the calibration table entries, the pedestal and the level. The channels are independent copies. A sample or a setting on one channel never reaches another.

Top module: `adc_baseline_bank`

## Requirements
- R1: While reset is held and right after it is released, every `vld_o`, `above_o` and `corr_o` bit is 0. The pedestal and the level of each channel reset to 0.
- R2: A sample whose `smp_vld_i` bit is high at a rising edge appears on that channel's outputs, with its `vld_o` bit high, after the fourth rising edge counted from that edge. `vld_o` is low on the cycle before.
- R3: After reset, with no table writes, the table is the identity mapping, so `corr_o` equals the raw code minus the pedestal.
- R4: A table write stores `lut_data_i` at `lut_addr_i` for channel `lut_ch_i` only. Later samples with that code on that channel give the stored value. Other codes, and other channels, keep their earlier mapping.
- R5: `corr_o` is the two's-complement difference (linearized value minus pedestal), 11 bits per channel, channel c in bits [11c+10:11c]. It spans -1023 to +1023 without wrapping.
- R6: `above_o` is high exactly when the signed result is strictly greater than the channel's signed 11-bit level. A result equal to the level gives 0. Negative levels compare as signed.
- R7: A pedestal or level write affects only the channel named by `base_ch_i` / `thr_ch_i`.
- R8: When a channel has no valid sample at its output, its `corr_o` and `above_o` hold the values of its last valid sample while its `vld_o` is low.
- R9: A valid sample on one channel never raises `vld_o` on another channel.
- R10: Samples on consecutive cycles come out on consecutive cycles, in order, each with its own result and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_raw_i | input | NUM_CH*10 | Raw codes, channel c in bits [10c+9:10c] |
| smp_vld_i | input | NUM_CH | Per-channel sample strobe |
| lut_we_i | input | 1 | Calibration table write enable |
| lut_ch_i | input | 3 | Channel selected for the table write |
| lut_addr_i | input | 10 | Raw code being remapped |
| lut_data_i | input | 10 | Linearized value stored for that code |
| base_we_i | input | 1 | Pedestal write enable |
| base_ch_i | input | 3 | Channel selected for the pedestal write |
| base_data_i | input | 10 | Pedestal value |
| thr_we_i | input | 1 | Level write enable |
| thr_ch_i | input | 3 | Channel selected for the level write |
| thr_data_i | input | 11 | Signed level |
| corr_o | output | NUM_CH*11 | Signed corrected samples |
| above_o | output | NUM_CH | Strictly-above-level flags |
| vld_o | output | NUM_CH | Output strobe aligned with data and flag |

## Verification
The assertions check, on every cycle and in every channel, that the output strobe is the input strobe delayed by four clocks. They also check that each output value is the table result minus the pedestal from two cycles earlier, that the flag agrees with the output value against the previous cycle's level, and that an unwritten table entry reads back as its own code. Only the bench's scenarios can show the actual numbers: negative results at the range limits, the equal-to-level boundary, a table write confined to one code of one channel, settings confined to one channel, output holding between samples, and back-to-back streaming.

// File: rtl/adcbl_pkg.sv
package adcbl_pkg;
  localparam int unsigned NUM_CH_DEF = 8;
  localparam int unsigned RAW_W_DEF  = 10;
  localparam int unsigned CAL_W_DEF  = 10;

  // width of an index that selects one of n items (at least one bit)
  function automatic int unsigned sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/adcbl_lut.sv
module adcbl_lut #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  prog_q, prog_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  // next-state: mark written entries, choose stored or identity value
  always_comb begin
    prog_d = prog_q;
    if (wr_en_i) prog_d[wr_addr_i] = 1'b1;
    rd_d = prog_q[rd_addr_i] ? mem[rd_addr_i] : DATA_W'(rd_addr_i);
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_en_i) prog_q <= prog_d;
      if (rd_en_i) rd_q   <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

  // R3: an entry never written reads back as its own code
  assert_ident_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !prog_q[rd_addr_i]) |=> (rd_q == DATA_W'($past(rd_addr_i))));
endmodule

// File: rtl/adcbl_chan.sv
module adcbl_chan #(
  parameter int unsigned RAW_W = 10,
  parameter int unsigned CAL_W = 10,
  localparam int unsigned OUT_W = CAL_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [RAW_W-1:0]        smp_i,
  input  logic                    vld_i,
  input  logic                    lut_we_i,
  input  logic [RAW_W-1:0]        lut_addr_i,
  input  logic [CAL_W-1:0]        lut_data_i,
  input  logic                    base_we_i,
  input  logic [CAL_W-1:0]        base_data_i,
  input  logic                    thr_we_i,
  input  logic signed [OUT_W-1:0] thr_data_i,
  output logic signed [OUT_W-1:0] corr_o,
  output logic                    above_o,
  output logic                    vld_o
);
  // stage 1: input capture
  logic [RAW_W-1:0] s1_raw_q;
  logic             s1_vld_q;
  // stage 2: table output (registered inside the table)
  logic [CAL_W-1:0] s2_lin;
  logic             s2_vld_q;
  // stage 3: difference
  logic signed [OUT_W-1:0] s3_diff_q, s3_diff_d;
  logic                    s3_vld_q;
  // stage 4: outputs
  logic signed [OUT_W-1:0] s4_diff_q;
  logic                    s4_flag_q, s4_flag_d;
  logic                    s4_vld_q;
  // host settings
  logic [CAL_W-1:0]        base_q;
  logic signed [OUT_W-1:0] thr_q;
  // cycles since reset, saturating; used by the checks below
  logic [2:0]              age_q, age_d;

  adcbl_lut #(.ADDR_W(RAW_W), .DATA_W(CAL_W)) u_lut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (lut_we_i),
    .wr_addr_i (lut_addr_i),
    .wr_data_i (lut_data_i),
    .rd_en_i   (s1_vld_q),
    .rd_addr_i (s1_raw_q),
    .rd_data_o (s2_lin)
  );

  always_comb begin
    s3_diff_d = $signed({1'b0, s2_lin}) - $signed({1'b0, base_q});
    s4_flag_d = (s3_diff_q > thr_q);
    age_d     = (age_q == 3'd7) ? age_q : age_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_raw_q  <= '0;
      s1_vld_q  <= 1'b0;
      s2_vld_q  <= 1'b0;
      s3_diff_q <= '0;
      s3_vld_q  <= 1'b0;
      s4_diff_q <= '0;
      s4_flag_q <= 1'b0;
      s4_vld_q  <= 1'b0;
      base_q    <= '0;
      thr_q     <= '0;
      age_q     <= '0;
    end else begin
      s1_vld_q <= vld_i;
      s2_vld_q <= s1_vld_q;
      s3_vld_q <= s2_vld_q;
      s4_vld_q <= s3_vld_q;
      age_q    <= age_d;
      if (vld_i)     s1_raw_q  <= smp_i;
      if (s2_vld_q)  s3_diff_q <= s3_diff_d;
      if (s3_vld_q) begin
        s4_diff_q <= s3_diff_q;
        s4_flag_q <= s4_flag_d;
      end
      if (base_we_i) base_q <= base_data_i;
      if (thr_we_i)  thr_q  <= thr_data_i;
    end
  end

  assign corr_o  = s4_diff_q;
  assign above_o = s4_flag_q;
  assign vld_o   = s4_vld_q;

  // R2: output strobe is the input strobe four clocks later
  assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4) |-> (vld_o == $past(vld_i, 4)));

  // R5: output equals table value minus pedestal from two cycles before
  assert_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd3 && vld_o) |->
      (corr_o == $signed({1'b0, $past(s2_lin, 2)}) - $signed({1'b0, $past(base_q, 2)})));

  // R6: flag agrees with the output value against the level in force
  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd1 && vld_o) |-> (above_o == (corr_o > $past(thr_q))));
endmodule

// File: rtl/adc_baseline_bank.sv
module adc_baseline_bank
  import adcbl_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned RAW_W  = RAW_W_DEF,
  parameter int unsigned CAL_W  = CAL_W_DEF,
  localparam int unsigned OUT_W = CAL_W + 1,
  localparam int unsigned CH_W  = sel_w(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic [NUM_CH*RAW_W-1:0]  smp_raw_i,
  input  logic [NUM_CH-1:0]        smp_vld_i,
  input  logic                     lut_we_i,
  input  logic [CH_W-1:0]          lut_ch_i,
  input  logic [RAW_W-1:0]         lut_addr_i,
  input  logic [CAL_W-1:0]         lut_data_i,
  input  logic                     base_we_i,
  input  logic [CH_W-1:0]          base_ch_i,
  input  logic [CAL_W-1:0]         base_data_i,
  input  logic                     thr_we_i,
  input  logic [CH_W-1:0]          thr_ch_i,
  input  logic [OUT_W-1:0]         thr_data_i,
  output logic [NUM_CH*OUT_W-1:0]  corr_o,
  output logic [NUM_CH-1:0]        above_o,
  output logic [NUM_CH-1:0]        vld_o
);
  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic lut_sel, base_sel, thr_sel;
    logic signed [OUT_W-1:0] corr_ch;

    assign lut_sel  = lut_we_i  && (lut_ch_i  == CH_W'(g));
    assign base_sel = base_we_i && (base_ch_i == CH_W'(g));
    assign thr_sel  = thr_we_i  && (thr_ch_i  == CH_W'(g));

    adcbl_chan #(.RAW_W(RAW_W), .CAL_W(CAL_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_i       (smp_raw_i[g*RAW_W +: RAW_W]),
      .vld_i       (smp_vld_i[g]),
      .lut_we_i    (lut_sel),
      .lut_addr_i  (lut_addr_i),
      .lut_data_i  (lut_data_i),
      .base_we_i   (base_sel),
      .base_data_i (base_data_i),
      .thr_we_i    (thr_sel),
      .thr_data_i  ($signed(thr_data_i)),
      .corr_o      (corr_ch),
      .above_o     (above_o[g]),
      .vld_o       (vld_o[g])
    );

    assign corr_o[g*OUT_W +: OUT_W] = corr_ch;
  end
endmodule

// File: tb/adc_baseline_bank_bench.sv
module adc_baseline_bank_bench;
  localparam int NCH = 8;
  localparam int RW  = 10;
  localparam int OW  = 11;
  localparam int WATCHDOG_CYC = 20000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH*RW-1:0] smp_raw = '0;
  logic [NCH-1:0]    smp_vld = '0;
  logic       lut_we = 1'b0;  logic [2:0] lut_ch = '0;
  logic [9:0] lut_addr = '0;  logic [9:0] lut_data = '0;
  logic       base_we = 1'b0; logic [2:0] base_ch = '0; logic [9:0] base_data = '0;
  logic       thr_we = 1'b0;  logic [2:0] thr_ch = '0;  logic [10:0] thr_data = '0;
  logic [NCH*OW-1:0] corr;
  logic [NCH-1:0]    above, vld;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_baseline_bank u_adc_baseline_bank (
    .clk(clk), .rst_ni(rst_ni), .smp_raw_i(smp_raw), .smp_vld_i(smp_vld),
    .lut_we_i(lut_we), .lut_ch_i(lut_ch), .lut_addr_i(lut_addr), .lut_data_i(lut_data),
    .base_we_i(base_we), .base_ch_i(base_ch), .base_data_i(base_data),
    .thr_we_i(thr_we), .thr_ch_i(thr_ch), .thr_data_i(thr_data),
    .corr_o(corr), .above_o(above), .vld_o(vld)
  );

  function automatic int corr_of(input int c);
    logic signed [OW-1:0] v;
    v = corr[c*OW +: OW];
    return int'(v);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr_base(input int c, input int v);
    @(negedge clk); base_we = 1'b1; base_ch = 3'(c); base_data = 10'(v);
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic wr_thr(input int c, input int v);
    @(negedge clk); thr_we = 1'b1; thr_ch = 3'(c); thr_data = 11'(v);
    @(negedge clk); thr_we = 1'b0;
  endtask

  task automatic wr_lut(input int c, input int a, input int d);
    @(negedge clk); lut_we = 1'b1; lut_ch = 3'(c); lut_addr = 10'(a); lut_data = 10'(d);
    @(negedge clk); lut_we = 1'b0;
  endtask

  // one sample on one channel, checked four edges later
  task automatic send_one(input int c, input int raw, input int exp_corr,
                          input int exp_flag, input string tag);
    @(negedge clk);
    smp_raw[c*RW +: RW] = 10'(raw); smp_vld[c] = 1'b1;
    @(negedge clk);
    smp_vld[c] = 1'b0;
    repeat (3) @(negedge clk);
    chk({tag, " vld"},  int'(vld[c]), 1);
    chk({tag, " corr"}, corr_of(c), exp_corr);
    chk({tag, " flag"}, int'(above[c]), exp_flag);
  endtask

  task automatic t_reset_r1;
    repeat (5) @(negedge clk);
    chk("R1 vld in reset", int'(vld), 0);
    chk("R1 flag in reset", int'(above), 0);
    chk("R1 corr in reset", int'(corr == '0), 1);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after release", int'(vld), 0);
    chk("R1 corr after release", int'(corr == '0), 1);
  endtask

  task automatic t_latency_r2;
    @(negedge clk);
    smp_raw[1*RW +: RW] = 10'd321; smp_vld[1] = 1'b1;
    @(negedge clk);
    smp_vld[1] = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 vld low one cycle early", int'(vld[1]), 0);
    @(negedge clk);
    chk("R2 vld after four edges", int'(vld[1]), 1);
    chk("R3 identity with zero pedestal", corr_of(1), 321);
    chk("R6 flag vs reset level 0", int'(above[1]), 1);
    chk("R9 no strobe on other channels", int'(vld & ~8'b0000_0010), 0);
  endtask

  task automatic t_negative_r5;
    wr_base(0, 1023);
    send_one(0, 0, -1023, 0, "R5 lowest result");
    send_one(0, 1023, 0, 0, "R5 zero result");
    wr_base(0, 0);
    send_one(0, 1023, 1023, 1, "R5 highest result");
  endtask

  task automatic t_level_r6;
    wr_base(4, 100);
    wr_thr(4, 50);
    send_one(4, 150, 50, 0, "R6 equal to level");
    send_one(4, 151, 51, 1, "R6 one above level");
    wr_thr(4, -10);
    send_one(4, 90, -10, 0, "R6 equal negative level");
    send_one(4, 91, -9, 1, "R6 above negative level");
    send_one(4, 20, -80, 0, "R6 below negative level");
  endtask

  task automatic t_table_r4;
    wr_lut(2, 7, 900);
    send_one(2, 7, 900, 1, "R4 written code");
    send_one(2, 8, 8, 1, "R4 neighbour code unchanged");
    send_one(3, 7, 7, 1, "R4 other channel unchanged");
  endtask

  task automatic t_isolation_r7;
    wr_base(5, 200);
    wr_thr(5, 100);
    @(negedge clk);
    smp_raw[5*RW +: RW] = 10'd250; smp_raw[6*RW +: RW] = 10'd250;
    smp_vld[5] = 1'b1; smp_vld[6] = 1'b1;
    @(negedge clk);
    smp_vld[5] = 1'b0; smp_vld[6] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 written channel pedestal", corr_of(5), 50);
    chk("R7 written channel level", int'(above[5]), 0);
    chk("R7 neighbour pedestal untouched", corr_of(6), 250);
    chk("R7 neighbour level untouched", int'(above[6]), 1);
  endtask

  task automatic t_hold_r8;
    send_one(7, 600, 600, 1, "R8 setup sample");
    repeat (3) @(negedge clk);
    chk("R8 strobe low while idle", int'(vld[7]), 0);
    chk("R8 data held", corr_of(7), 600);
    chk("R8 flag held", int'(above[7]), 1);
  endtask

  task automatic t_stream_r10;
    // channel 6: pedestal 0, level 500
    wr_thr(6, 500);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        int r;
        r = ((i - 4) * 61) % 1024;
        chk("R10 stream strobe", int'(vld[6]), 1);
        chk("R10 stream data", corr_of(6), r);
        chk("R10 stream flag", int'(above[6]), (r > 500) ? 1 : 0);
      end
      if (i < 16) begin
        smp_raw[6*RW +: RW] = 10'((i * 61) % 1024);
        smp_vld[6] = 1'b1;
      end else begin
        smp_vld[6] = 1'b0;
      end
    end
  endtask

  initial begin
    t_reset_r1();
    t_latency_r2();
    t_negative_r5();
    t_level_r6();
    t_table_r4();
    t_isolation_r7();
    t_hold_r8();
    t_stream_r10();
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule